// File: doc/BRIEF.md
# Host Bridge Window Register File

This block is the software-visible register file of a host-to-peripheral-bus bridge. It sits behind a simple valid/ready request channel on a 4 KB address region. It holds, for each of four address windows, a window base, a window size mask and a translated base, plus one 64-bit bridge control word. All stored values drive a neighbouring address translator directly through flat output vectors. Every register is 64 bits wide and occupies its own 64-byte slot. Only full 8-byte accesses are legal.

A few slots exist only so that software can poll them or poke them. The error status and error mask slots always read zero. The translation-cache flush slot reads zero, and a write to it produces a single-cycle flush strobe for the downstream cache. Slots with no implementation, undefined slots, addresses outside the region and wrong access sizes are all refused with an error code, and register state stays unchanged. Every accepted request gets exactly one response, one cycle after acceptance.

Top module: `hbr_csr_file`

## Requirements
- R1: After reset, every window base, mask and translated base output is zero. `ctrl_o` equals 64'h0000_0021_0010_0000, which is bit 20 set, bit 32 set, and 2 in the 4-bit field at bit 36. No response and no flush strobe is active.
- R2: The slot number is address bits [11:6] of the byte offset from `REGION_BASE`, and bits [5:0] are ignored. The default slot map is as follows. Slots 0-3 are window bases 0-3, slots 4-7 are masks 0-3, slots 8-11 are translated bases 0-3, and slot 12 is control. Slot 15 is error status, slot 16 is error mask and slot 19 is flush. Slots 13, 14, 17, 18, 20 and 21 are unimplemented. All other slots are undefined.
- R3: A write with response code 2'b00 to any of the thirteen storage slots updates that register. A later read returns the written value, and the matching output vector (window w at bits [w*64 +: 64]) follows it.
- R4: Reads of the error status and error mask slots return zero with code 2'b00. A write to error status is accepted with code 2'b00 and changes nothing.
- R5: A read of the flush slot returns zero with code 2'b00. A write to it returns code 2'b00 and raises `tlb_inval_o` for exactly the cycle in which that response is presented.
- R6: Any access to an unimplemented slot, and any write to the error mask slot, returns code 2'b10 with zero data and changes no register.
- R7: Any access to an undefined slot, or to an address whose bits above bit 11 differ from `REGION_BASE`, returns code 2'b11 with zero data and changes no register.
- R8: An in-region access whose size code is not 2'd3 (8 bytes) returns code 2'b10 with zero data and changes no register.
- R9: `req_ready_o` is high once reset has been released. Each accepted request produces `rsp_valid_o` in the next cycle only. A read returns the value left by every write accepted before it, including a write accepted in the immediately preceding cycle. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | Access size code, 3 = 8 bytes |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after acceptance |
| rsp_code_o | output | 2 | 00 ok, 10 refused, 11 decode miss |
| rsp_rdata_o | output | 64 | Read data |
| win_base_o | output | NWIN*64 | Window base registers, flat |
| win_mask_o | output | NWIN*64 | Window mask registers, flat |
| win_xlat_o | output | NWIN*64 | Translated base registers, flat |
| ctrl_o | output | 64 | Bridge control register |
| tlb_inval_o | output | 1 | Single-cycle translation-cache flush strobe |

## Verification
Two functions can fall in the same cycle. A register update from a write accepted at one edge coincides with the read-data capture of the request accepted at the very next edge, and the flush strobe coincides with the presentation of the response. The bench drives each write immediately followed by a read of the same slot, with no idle cycle between them. The read response must carry the new value. It also checks that the flush strobe is high exactly when the scoreboard pops the flush write's response and low at all other times.

// File: rtl/hbr_csr_pkg.sv
package hbr_csr_pkg;

  localparam int unsigned DATA_W = 64;
  localparam logic [1:0]  SIZE_DWORD = 2'd3;
  localparam logic [DATA_W-1:0] CTRL_RST = 64'h0000_0021_0010_0000;

  typedef enum logic [1:0] {
    RSP_OK  = 2'b00,
    RSP_SLV = 2'b10,
    RSP_DEC = 2'b11
  } rsp_code_e;

  typedef enum logic [3:0] {
    K_WBASE,
    K_WMASK,
    K_XLAT,
    K_CTRL,
    K_ZERO_RW,   // reads zero, writes dropped
    K_ZERO_RO,   // reads zero, writes refused
    K_INVALL,
    K_UNIMP,
    K_UNDEF,
    K_OUTSIDE,
    K_BADSIZE
  } kind_e;

endpackage

// File: rtl/hbr_csr_decode.sv
module hbr_csr_decode
  import hbr_csr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h0001_0000,
  parameter int unsigned NWIN        = 4,
  parameter int unsigned IDX_WBASE   = 0,
  parameter int unsigned IDX_WMASK   = 4,
  parameter int unsigned IDX_XLAT    = 8,
  parameter int unsigned IDX_CTRL    = 12,
  parameter int unsigned IDX_LAT     = 13,
  parameter int unsigned IDX_RSVD    = 14,
  parameter int unsigned IDX_ERRSTAT = 15,
  parameter int unsigned IDX_ERRMASK = 16,
  parameter int unsigned IDX_ERRSET  = 17,
  parameter int unsigned IDX_INV1    = 18,
  parameter int unsigned IDX_INVALL  = 19,
  parameter int unsigned IDX_MONCTL  = 20,
  parameter int unsigned IDX_MONCNT  = 21
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              write_i,
  output kind_e             kind_o,
  output logic [NWIN-1:0]   win_sel_o,
  output rsp_code_e         code_o
);

  localparam int unsigned REGION_LG = 12;
  localparam int unsigned SLOT_LG   = 6;
  localparam int unsigned SLOT_W    = REGION_LG - SLOT_LG;

  logic [SLOT_W-1:0] slot;
  logic [31:0]       slot_ext;
  logic              in_region;
  logic [NWIN-1:0]   hit_base, hit_mask, hit_xlat;
  logic              hit_unimp;

  assign slot      = addr_i[REGION_LG-1:SLOT_LG];
  assign slot_ext  = 32'(slot);
  assign in_region = (addr_i[ADDR_W-1:REGION_LG] == REGION_BASE[ADDR_W-1:REGION_LG]);

  for (genvar w = 0; w < NWIN; w++) begin : g_hit
    assign hit_base[w] = (slot_ext == 32'(IDX_WBASE + w));
    assign hit_mask[w] = (slot_ext == 32'(IDX_WMASK + w));
    assign hit_xlat[w] = (slot_ext == 32'(IDX_XLAT + w));
  end

  assign hit_unimp = (slot_ext == 32'(IDX_LAT))    || (slot_ext == 32'(IDX_RSVD))   ||
                     (slot_ext == 32'(IDX_ERRSET)) || (slot_ext == 32'(IDX_INV1))   ||
                     (slot_ext == 32'(IDX_MONCTL)) || (slot_ext == 32'(IDX_MONCNT));

  always_comb begin
    kind_o = K_UNDEF;
    if (!in_region)                              kind_o = K_OUTSIDE;
    else if (size_i != SIZE_DWORD)               kind_o = K_BADSIZE;
    else if (|hit_base)                          kind_o = K_WBASE;
    else if (|hit_mask)                          kind_o = K_WMASK;
    else if (|hit_xlat)                          kind_o = K_XLAT;
    else if (slot_ext == 32'(IDX_CTRL))          kind_o = K_CTRL;
    else if (slot_ext == 32'(IDX_ERRSTAT))       kind_o = K_ZERO_RW;
    else if (slot_ext == 32'(IDX_ERRMASK))       kind_o = K_ZERO_RO;
    else if (slot_ext == 32'(IDX_INVALL))        kind_o = K_INVALL;
    else if (hit_unimp)                          kind_o = K_UNIMP;
  end

  assign win_sel_o = hit_base | hit_mask | hit_xlat;

  always_comb begin
    unique case (kind_o)
      K_OUTSIDE, K_UNDEF: code_o = RSP_DEC;
      K_BADSIZE, K_UNIMP: code_o = RSP_SLV;
      K_ZERO_RO:          code_o = write_i ? RSP_SLV : RSP_OK;
      default:            code_o = RSP_OK;
    endcase
  end

endmodule

// File: rtl/hbr_csr_store.sv
module hbr_csr_store
  import hbr_csr_pkg::*;
#(
  parameter int unsigned NWIN = 4,
  parameter int unsigned DW   = DATA_W,
  parameter logic [DW-1:0] CTRL_INIT = CTRL_RST
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  kind_e              kind_i,
  input  logic [NWIN-1:0]    win_sel_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NWIN*DW-1:0] base_o,
  output logic [NWIN*DW-1:0] mask_o,
  output logic [NWIN*DW-1:0] xlat_o,
  output logic [DW-1:0]      ctrl_o,
  output logic [DW-1:0]      rdata_o
);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [DW-1:0] base_q, mask_q, xlat_q;
    logic          base_en, mask_en, xlat_en;

    assign base_en = we_i && win_sel_i[w] && (kind_i == K_WBASE);
    assign mask_en = we_i && win_sel_i[w] && (kind_i == K_WMASK);
    assign xlat_en = we_i && win_sel_i[w] && (kind_i == K_XLAT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      base_q <= '0;
      else if (base_en) base_q <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mask_q <= '0;
      else if (mask_en) mask_q <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      xlat_q <= '0;
      else if (xlat_en) xlat_q <= wdata_i;
    end

    assign base_o[w*DW +: DW] = base_q;
    assign mask_o[w*DW +: DW] = mask_q;
    assign xlat_o[w*DW +: DW] = xlat_q;
  end

  logic [DW-1:0] ctrl_q, ctrl_d;
  logic          ctrl_en;

  assign ctrl_en = we_i && (kind_i == K_CTRL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_en) ctrl_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_INIT;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  logic [DW-1:0] sel_base, sel_mask, sel_xlat;

  always_comb begin
    sel_base = '0;
    sel_mask = '0;
    sel_xlat = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (win_sel_i[w]) begin
        sel_base = sel_base | base_o[w*DW +: DW];
        sel_mask = sel_mask | mask_o[w*DW +: DW];
        sel_xlat = sel_xlat | xlat_o[w*DW +: DW];
      end
    end
  end

  always_comb begin
    unique case (kind_i)
      K_WBASE: rdata_o = sel_base;
      K_WMASK: rdata_o = sel_mask;
      K_XLAT:  rdata_o = sel_xlat;
      K_CTRL:  rdata_o = ctrl_q;
      default: rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/hbr_csr_rsp.sv
module hbr_csr_rsp
  import hbr_csr_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          write_i,
  input  rsp_code_e     code_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          inval_i,
  output logic          rsp_valid_o,
  output rsp_code_e     rsp_code_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          inval_o
);

  logic          valid_q, valid_d;
  rsp_code_e     code_q, code_d;
  logic [DW-1:0] data_q, data_d;
  logic          inval_q, inval_d;

  always_comb begin
    valid_d = accept_i;
    inval_d = accept_i && inval_i;
    code_d  = code_q;
    data_d  = data_q;
    if (accept_i) begin
      code_d = code_i;
      data_d = (code_i == RSP_OK && !write_i) ? rdata_i : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      inval_q <= 1'b0;
      code_q  <= RSP_OK;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      inval_q <= inval_d;
      code_q  <= code_d;
      data_q  <= data_d;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_code_o  = code_q;
  assign rsp_rdata_o = data_q;
  assign inval_o     = inval_q;

endmodule

// File: rtl/hbr_csr_file.sv
module hbr_csr_file
  import hbr_csr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h0001_0000,
  parameter int unsigned NWIN        = 4,
  parameter int unsigned IDX_WBASE   = 0,
  parameter int unsigned IDX_WMASK   = 4,
  parameter int unsigned IDX_XLAT    = 8,
  parameter int unsigned IDX_CTRL    = 12,
  parameter int unsigned IDX_LAT     = 13,
  parameter int unsigned IDX_RSVD    = 14,
  parameter int unsigned IDX_ERRSTAT = 15,
  parameter int unsigned IDX_ERRMASK = 16,
  parameter int unsigned IDX_ERRSET  = 17,
  parameter int unsigned IDX_INV1    = 18,
  parameter int unsigned IDX_INVALL  = 19,
  parameter int unsigned IDX_MONCTL  = 20,
  parameter int unsigned IDX_MONCNT  = 21
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_write_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [1:0]             req_size_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  output logic                   rsp_valid_o,
  output logic [1:0]             rsp_code_o,
  output logic [DATA_W-1:0]      rsp_rdata_o,
  output logic [NWIN*DATA_W-1:0] win_base_o,
  output logic [NWIN*DATA_W-1:0] win_mask_o,
  output logic [NWIN*DATA_W-1:0] win_xlat_o,
  output logic [DATA_W-1:0]      ctrl_o,
  output logic                   tlb_inval_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_n = rst_sync_q[1];

  logic ready_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign req_ready_o = ready_q;

  logic            accept;
  kind_e           dec_kind;
  logic [NWIN-1:0] dec_sel;
  rsp_code_e       dec_code;
  logic [DATA_W-1:0] rd_data;
  logic            wr_ok;
  rsp_code_e       rsp_code;

  assign accept = req_valid_i && ready_q;
  assign wr_ok  = accept && req_write_i && (dec_code == RSP_OK);

  hbr_csr_decode #(
    .ADDR_W(ADDR_W), .REGION_BASE(REGION_BASE), .NWIN(NWIN),
    .IDX_WBASE(IDX_WBASE), .IDX_WMASK(IDX_WMASK), .IDX_XLAT(IDX_XLAT),
    .IDX_CTRL(IDX_CTRL), .IDX_LAT(IDX_LAT), .IDX_RSVD(IDX_RSVD),
    .IDX_ERRSTAT(IDX_ERRSTAT), .IDX_ERRMASK(IDX_ERRMASK),
    .IDX_ERRSET(IDX_ERRSET), .IDX_INV1(IDX_INV1), .IDX_INVALL(IDX_INVALL),
    .IDX_MONCTL(IDX_MONCTL), .IDX_MONCNT(IDX_MONCNT)
  ) u_decode (
    .addr_i    (req_addr_i),
    .size_i    (req_size_i),
    .write_i   (req_write_i),
    .kind_o    (dec_kind),
    .win_sel_o (dec_sel),
    .code_o    (dec_code)
  );

  hbr_csr_store #(.NWIN(NWIN), .DW(DATA_W), .CTRL_INIT(CTRL_RST)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .we_i      (wr_ok),
    .kind_i    (dec_kind),
    .win_sel_i (dec_sel),
    .wdata_i   (req_wdata_i),
    .base_o    (win_base_o),
    .mask_o    (win_mask_o),
    .xlat_o    (win_xlat_o),
    .ctrl_o    (ctrl_o),
    .rdata_o   (rd_data)
  );

  hbr_csr_rsp #(.DW(DATA_W)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .accept_i    (accept),
    .write_i     (req_write_i),
    .code_i      (dec_code),
    .rdata_i     (rd_data),
    .inval_i     (req_write_i && (dec_kind == K_INVALL) && (dec_code == RSP_OK)),
    .rsp_valid_o (rsp_valid_o),
    .rsp_code_o  (rsp_code),
    .rsp_rdata_o (rsp_rdata_o),
    .inval_o     (tlb_inval_o)
  );

  assign rsp_code_o = rsp_code;

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> rsp_valid_o); // R9

  AST_ZERO_SLOTS_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (accept && !req_write_i && (dec_kind == K_ZERO_RW || dec_kind == K_ZERO_RO || dec_kind == K_INVALL))
    |=> (rsp_rdata_o == '0 && rsp_code_o == RSP_OK)); // R4

  AST_FLUSH_WITH_OK_RSP: assert property (@(posedge clk_i) disable iff (!rst_n)
    tlb_inval_o |-> (rsp_valid_o && rsp_code_o == RSP_OK)); // R5

  AST_REFUSED_HOLDS_STATE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (accept && dec_code != RSP_OK) |=> ($stable(ctrl_o) && $stable(win_base_o) &&
                                        $stable(win_mask_o) && $stable(win_xlat_o))); // R6

  AST_REFUSED_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_n)
    (accept && dec_code != RSP_OK) |=> (rsp_rdata_o == '0 && rsp_code_o != RSP_OK)); // R7

endmodule

// File: tb/hbr_csr_file_bench.sv
`timescale 1ns/1ps
module hbr_csr_file_bench;
  import hbr_csr_pkg::*;

  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic          req_ready;
  logic [31:0]   req_addr = '0;
  logic [1:0]    req_size = 2'd3;
  logic [63:0]   req_wdata = '0;
  logic          rsp_valid, inval;
  logic [1:0]    rsp_code;
  logic [63:0]   rsp_rdata, ctrl;
  logic [NW*64-1:0] wbase, wmask, wxlat;

  hbr_csr_file u_hbr_csr_file (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code), .rsp_rdata_o(rsp_rdata),
    .win_base_o(wbase), .win_mask_o(wmask), .win_xlat_o(wxlat),
    .ctrl_o(ctrl), .tlb_inval_o(inval)
  );

  typedef struct {
    logic [1:0]  code;
    logic [63:0] data;
    logic        inv;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [63:0] model [0:12];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_rd(input int slot);
    return (slot < 13) ? model[slot] : 64'h0;
  endfunction

  function automatic logic [63:0] pat(input int i);
    return {32'hC0DE_0000 | 32'(i), 32'h1234_5678 ^ (32'(i) * 32'h0101_0101)};
  endfunction

  task automatic xfer(input bit wr, input logic [31:0] addr, input logic [1:0] sz,
                      input logic [63:0] wd, input logic [1:0] ecode,
                      input logic [63:0] edata, input bit einv, input string tag);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
    e.code = ecode; e.data = edata; e.inv = einv; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] sa(input int slot);
    return BASE + 32'(slot) * 32'd64;
  endfunction

  task automatic rd_ok(input int slot, input string tag);
    xfer(1'b0, sa(slot), 2'd3, 64'h0, 2'b00, exp_rd(slot), 1'b0, tag);
  endtask

  task automatic wr_ok(input int slot, input logic [63:0] d, input string tag);
    xfer(1'b1, sa(slot), 2'd3, d, 2'b00, 64'h0, 1'b0, tag);
    if (slot < 13) model[slot] = d;
  endtask

  task automatic check_outputs(input string tag);
    for (int w = 0; w < NW; w++) begin
      chk({tag, " base"}, wbase[w*64 +: 64], model[w]);
      chk({tag, " mask"}, wmask[w*64 +: 64], model[4 + w]);
      chk({tag, " xlat"}, wxlat[w*64 +: 64], model[8 + w]);
    end
    chk({tag, " ctrl"}, ctrl, model[12]);
  endtask

  // monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R9: actual unexpected response expected none");
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " code"}, 64'(rsp_code), 64'(e.code));
          chk({e.tag, " data"}, rsp_rdata, e.data);
          chk({e.tag, " flush"}, 64'(inval), 64'(e.inv));
        end
      end else if (inval) begin
        n_chk++; n_fail++;
        $display("FAIL R5: actual flush without response expected none");
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 13; i++) model[i] = 64'h0;
    model[12] = 64'h0000_0021_0010_0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_outputs("R1 reset");
    chk("R1 rsp_valid", 64'(rsp_valid), 64'h0);
    chk("R1 flush", 64'(inval), 64'h0);
    chk("R9 ready after reset", 64'(req_ready), 64'h1);
    rd_ok(12, "R1 ctrl read");

    // R3/R9: each storage slot, write then immediate read of the same slot
    for (int s = 0; s < 13; s++) begin
      wr_ok(s, pat(s), "R3 write");
      rd_ok(s, "R9 back-to-back read");
    end
    idle();
    check_outputs("R3 outputs");
    for (int s = 0; s < 13; s++) rd_ok(s, "R3 readback");

    // R2: low six offset bits ignored
    xfer(1'b1, sa(1) + 32'h38, 2'd3, 64'hDEAD_BEEF_0000_0001, 2'b00, 64'h0, 1'b0, "R2 alias write");
    model[1] = 64'hDEAD_BEEF_0000_0001;
    xfer(1'b0, sa(1) + 32'h08, 2'd3, 64'h0, 2'b00, model[1], 1'b0, "R2 alias read");

    // R4: zero slots
    wr_ok(15, 64'hFFFF_FFFF_FFFF_FFFF, "R4 errstat write");
    rd_ok(15, "R4 errstat read");
    rd_ok(16, "R4 errmask read");

    // R5: flush slot
    xfer(1'b1, sa(19), 2'd3, 64'h1234, 2'b00, 64'h0, 1'b1, "R5 flush write");
    rd_ok(19, "R5 flush read");
    xfer(1'b1, sa(19), 2'd3, 64'h0, 2'b00, 64'h0, 1'b1, "R5 flush write again");
    rd_ok(0, "R5 next rsp no flush");

    // R6: unimplemented and errmask write
    begin
      int unimp [6] = '{13, 14, 17, 18, 20, 21};
      foreach (unimp[k]) begin
        xfer(1'b0, sa(unimp[k]), 2'd3, 64'h0, 2'b10, 64'h0, 1'b0, "R6 unimp read");
        xfer(1'b1, sa(unimp[k]), 2'd3, 64'h5555, 2'b10, 64'h0, 1'b0, "R6 unimp write");
      end
    end
    xfer(1'b1, sa(16), 2'd3, 64'h77, 2'b10, 64'h0, 1'b0, "R6 errmask write");

    // R7: undefined slots and outside region
    xfer(1'b1, sa(22), 2'd3, 64'h99, 2'b11, 64'h0, 1'b0, "R7 undef 22");
    xfer(1'b0, sa(40), 2'd3, 64'h0, 2'b11, 64'h0, 1'b0, "R7 undef 40");
    xfer(1'b1, sa(63), 2'd3, 64'h99, 2'b11, 64'h0, 1'b0, "R7 undef 63");
    xfer(1'b1, BASE + 32'h1000, 2'd3, 64'hAA, 2'b11, 64'h0, 1'b0, "R7 above region");
    xfer(1'b0, BASE - 32'd64, 2'd3, 64'h0, 2'b11, 64'h0, 1'b0, "R7 below region");

    // R8: bad sizes on control and a window
    for (int z = 0; z < 3; z++) begin
      xfer(1'b1, sa(12), 2'(z), 64'hBAD0, 2'b10, 64'h0, 1'b0, "R8 bad size write");
      xfer(1'b0, sa(2), 2'(z), 64'h0, 2'b10, 64'h0, 1'b0, "R8 bad size read");
    end

    // state unchanged after all refused accesses (R6 R7 R8)
    idle();
    check_outputs("R6 R7 R8 state held");
    for (int s = 0; s < 13; s++) rd_ok(s, "R6 R7 R8 readback");
    idle();
    idle();
    chk("R9 scoreboard drained", 64'(sb.size()), 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule